// File: doc/BRIEF.md
# Parallel Bus Cycle Sequencer

This block runs single read or write accesses on an asynchronous, memory-style parallel bus for one chip-select region. A host offers an access as address, write data and direction. The sequencer then drives chip enable, a read strobe (output enable) or a write strobe (write enable), the address and the outgoing data. Read data is captured from the bus, and the host gets a one-cycle completion pulse together with the read data.

Every phase of the access is counted in units. One unit is 1, 2, 4 or 8 clocks, chosen by a 2-bit multiplier code whose encoding is not in numeric order. An access has these phases in order:

1. Chip-enable-to-strobe setup, which may be zero.
2. Strobe.
3. Hold, with chip enable still asserted.
4. Idle pause, before another access may start.

The region configuration and the timing fields are captured when an access is accepted. When wait mode is on, a device ready line can stretch the strobe. That line passes through a two-flop synchronizer before it is used. A region whose enable bit is clear ignores requests.

Top module: `pbus_cycle_seq`

## Requirements
- R1: After reset `bus_ce_n`, `bus_oe_n` and `bus_we_n` are 1, `bus_dout_en` and `rsp_done` are 0, and `req_ready` is 1.
- R2: The multiplier code `cfg_mult` sets the clocks per unit: code 0 gives 4, code 1 gives 1, code 2 gives 2 and code 3 gives 8. Every phase length below is its unit count times this factor.
- R3: The setup phase lasts `tim_setup` units. During setup chip enable is low and both strobes are high. A value of zero removes the phase, so the strobe starts in the first clock in which chip enable is low.
- R4: The strobe phase lasts field+1 units. The field is `tim_rd_strobe` for a read, which drives `bus_oe_n` low. The field is `tim_wr_strobe` for a write, which drives `bus_we_n` low. The two strobes are never low together, and neither is low while chip enable is high.
- R5: The hold phase lasts field+1 units, using `tim_rd_hold` or `tim_wr_hold`. Chip enable stays low and both strobes are high.
- R6: The pause phase lasts `tim_pause`+1 units with chip enable high. `req_ready` returns to 1 only after the pause ends.
- R7: With `cfg_wait_en` set, the strobe does not end while the synchronized `bus_ready` is low. If `bus_ready` goes high just before clock edge k, the strobe ends at the later of its programmed end and edge k+2.
- R8: With `cfg_wait_en` clear, `bus_ready` has no effect on the strobe length.
- R9: On a read, `rsp_rdata` takes `bus_din` at the clock edge where `bus_oe_n` goes high. It keeps that value until the next read captures data. Writes leave it unchanged.
- R10: `rsp_done` is a single-cycle pulse in the first clock after chip enable is released. `rsp_rdata` is valid in that cycle.
- R11: While `cfg_enable` is 0, a request causes no bus activity and no `rsp_done`.
- R12: `req_ready` is low from the accepting edge until the pause completes. Requests offered while it is low are ignored.
- R13: The multiplier, wait mode and timing fields are captured at acceptance. Changing them during an access has no effect on it.
- R14: On a write, `bus_dout` carries the write data and `bus_dout_en` is high while chip enable is low. On a read, `bus_dout_en` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host offers an access |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| cfg_enable | input | 1 | Region enable |
| cfg_mult | input | 2 | Multiplier code (0:x4, 1:x1, 2:x2, 3:x8) |
| cfg_wait_en | input | 1 | Let the ready line stretch the strobe |
| tim_setup | input | TIM_W | Chip-enable-to-strobe units (plain count) |
| tim_rd_strobe | input | TIM_W | Read strobe units, minus one |
| tim_wr_strobe | input | TIM_W | Write strobe units, minus one |
| tim_rd_hold | input | TIM_W | Read hold units, minus one |
| tim_wr_hold | input | TIM_W | Write hold units, minus one |
| tim_pause | input | TIM_W | Pause units, minus one |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_oe_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_addr | output | ADDR_W | Bus address |
| bus_dout | output | DATA_W | Outgoing data |
| bus_dout_en | output | 1 | Drive enable for outgoing data |
| bus_din | input | DATA_W | Incoming data |
| bus_ready | input | 1 | Device ready, asynchronous |
| rsp_done | output | 1 | Access complete pulse |
| rsp_rdata | output | DATA_W | Captured read data |

## Verification
Some properties are checked on every cycle:
- The two strobes are exclusive, and neither is active outside chip enable.
- An accepted request asserts chip enable on the next edge.
- A disabled region never raises chip enable.
- A stalled strobe persists while the synchronized ready line is low.
- The completion pulse lasts one cycle and follows the release of chip enable.
- Read data changes only at the rising edge of the read strobe.

Other behaviour is shown only by the bench scenarios:
- The exact clock count of each phase, for every multiplier code.
- The stretch that a ready line held low for a random time adds to the strobe.
- That configuration changed mid-access has no effect on that access.
- Which data value is sampled while the input changes every cycle of the strobe.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_PAUSE  = 3'd4
    } phase_e;

    // Multiplier code to log2(clocks per unit): 0->x4, 1->x1, 2->x2, 3->x8
    function automatic logic [1:0] mult_shift(input logic [1:0] code);
        logic [1:0] sh;
        case (code)
            2'd0:    sh = 2'd2;
            2'd1:    sh = 2'd0;
            2'd2:    sh = 2'd1;
            default: sh = 2'd3;
        endcase
        return sh;
    endfunction

endpackage

// File: rtl/pbs_unit_scale.sv
module pbs_unit_scale
    import pbs_pkg::*;
#(
    parameter int UNIT_W = 7,
    parameter int CNT_W  = UNIT_W + 3
) (
    input  logic [UNIT_W-1:0] units,
    input  logic [1:0]        mult_code,
    output logic [CNT_W-1:0]  clocks_m1
);
    logic [CNT_W-1:0] wide;

    always_comb begin
        wide      = CNT_W'(units);
        clocks_m1 = (wide << mult_shift(mult_code)) - CNT_W'(1);
    end

endmodule

// File: rtl/pbs_ready_sync.sv
module pbs_ready_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] sync_d, sync_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sync_d = async_in;
        end else begin : g_chain
            always_comb sync_d = {sync_q[STAGES-2:0], async_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_out = sync_q[STAGES-1];

endmodule

// File: rtl/pbs_phase_timer.sv
module pbs_phase_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)                cnt_d = load_val;
        else if (cnt_q != '0)    cnt_d = cnt_q - CNT_W'(1);
        else                     cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/pbus_cycle_seq.sv
module pbus_cycle_seq
    import pbs_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int TIM_W       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cfg_enable,
    input  logic [1:0]        cfg_mult,
    input  logic              cfg_wait_en,
    input  logic [TIM_W-1:0]  tim_setup,
    input  logic [TIM_W-1:0]  tim_rd_strobe,
    input  logic [TIM_W-1:0]  tim_wr_strobe,
    input  logic [TIM_W-1:0]  tim_rd_hold,
    input  logic [TIM_W-1:0]  tim_wr_hold,
    input  logic [TIM_W-1:0]  tim_pause,
    output logic              bus_ce_n,
    output logic              bus_oe_n,
    output logic              bus_we_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_dout_en,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              bus_ready,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int UNIT_W = TIM_W + 1;
    localparam int CNT_W  = UNIT_W + 3;

    typedef struct packed {
        phase_e             state;
        logic               write;
        logic               wait_en;
        logic [1:0]         mult;
        logic [TIM_W-1:0]   setup;
        logic [TIM_W-1:0]   strobe;
        logic [TIM_W-1:0]   hold;
        logic [TIM_W-1:0]   pause;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
        logic [DATA_W-1:0]  rdata;
        logic               ce_n;
        logic               oe_n;
        logic               we_n;
        logic               dout_en;
        logic               done;
    } seq_t;

    seq_t              seq_d, seq_q;
    logic              rdy_sync;
    logic              tmr_load;
    logic              tmr_expired;
    logic [UNIT_W-1:0] ld_units;
    logic [1:0]        ld_mult;
    logic [CNT_W-1:0]  ld_clocks;
    logic [TIM_W-1:0]  acc_strobe;
    logic              strobe_may_end;

    pbs_ready_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (bus_ready),
        .sync_out (rdy_sync)
    );

    pbs_unit_scale #(.UNIT_W(UNIT_W), .CNT_W(CNT_W)) u_scale (
        .units     (ld_units),
        .mult_code (ld_mult),
        .clocks_m1 (ld_clocks)
    );

    pbs_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (ld_clocks),
        .expired  (tmr_expired)
    );

    assign acc_strobe     = req_write ? tim_wr_strobe : tim_rd_strobe;
    assign strobe_may_end = tmr_expired && (!seq_q.wait_en || rdy_sync);

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        tmr_load   = 1'b0;
        ld_units   = '0;
        ld_mult    = seq_q.mult;

        case (seq_q.state)
            PH_IDLE: begin
                if (req_valid && cfg_enable) begin
                    seq_d.write   = req_write;
                    seq_d.wait_en = cfg_wait_en;
                    seq_d.mult    = cfg_mult;
                    seq_d.setup   = tim_setup;
                    seq_d.strobe  = acc_strobe;
                    seq_d.hold    = req_write ? tim_wr_hold : tim_rd_hold;
                    seq_d.pause   = tim_pause;
                    seq_d.addr    = req_addr;
                    seq_d.wdata   = req_wdata;
                    ld_mult       = cfg_mult;
                    tmr_load      = 1'b1;
                    if (tim_setup != '0) begin
                        seq_d.state = PH_SETUP;
                        ld_units    = {1'b0, tim_setup};
                    end else begin
                        seq_d.state = PH_STROBE;
                        ld_units    = {1'b0, acc_strobe} + UNIT_W'(1);
                    end
                end
            end
            PH_SETUP: begin
                if (tmr_expired) begin
                    seq_d.state = PH_STROBE;
                    ld_units    = {1'b0, seq_q.strobe} + UNIT_W'(1);
                    tmr_load    = 1'b1;
                end
            end
            PH_STROBE: begin
                if (strobe_may_end) begin
                    seq_d.state = PH_HOLD;
                    ld_units    = {1'b0, seq_q.hold} + UNIT_W'(1);
                    tmr_load    = 1'b1;
                    if (!seq_q.write) seq_d.rdata = bus_din;
                end
            end
            PH_HOLD: begin
                if (tmr_expired) begin
                    seq_d.state = PH_PAUSE;
                    seq_d.done  = 1'b1;
                    ld_units    = {1'b0, seq_q.pause} + UNIT_W'(1);
                    tmr_load    = 1'b1;
                end
            end
            PH_PAUSE: begin
                if (tmr_expired) seq_d.state = PH_IDLE;
            end
            default: seq_d.state = PH_IDLE;
        endcase

        seq_d.ce_n    = !(seq_d.state == PH_SETUP || seq_d.state == PH_STROBE ||
                          seq_d.state == PH_HOLD);
        seq_d.oe_n    = !(seq_d.state == PH_STROBE && !seq_d.write);
        seq_d.we_n    = !(seq_d.state == PH_STROBE &&  seq_d.write);
        seq_d.dout_en = seq_d.write && !seq_d.ce_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q      <= '0;
            seq_q.ce_n <= 1'b1;
            seq_q.oe_n <= 1'b1;
            seq_q.we_n <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready   = (seq_q.state == PH_IDLE);
    assign bus_ce_n    = seq_q.ce_n;
    assign bus_oe_n    = seq_q.oe_n;
    assign bus_we_n    = seq_q.we_n;
    assign bus_addr    = seq_q.addr;
    assign bus_dout    = seq_q.wdata;
    assign bus_dout_en = seq_q.dout_en;
    assign rsp_done    = seq_q.done;
    assign rsp_rdata   = seq_q.rdata;

    // Assertions
    assert_accept_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && cfg_enable) |=> !bus_ce_n);

    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_oe_n && !bus_we_n));

    assert_strobe_in_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_oe_n || !bus_we_n) |-> !bus_ce_n);

    assert_wait_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == PH_STROBE && seq_q.wait_en && !rdy_sync) |=> (seq_q.state == PH_STROBE));

    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(bus_oe_n) |-> $stable(rsp_rdata));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    assert_done_after_ce_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (bus_ce_n && $past(!bus_ce_n)));

    assert_disabled_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !cfg_enable) |=> bus_ce_n);

    assert_dout_en_R14: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dout_en |-> (!bus_ce_n && bus_oe_n));

endmodule

// File: tb/pbus_cycle_seq_bench.sv
`timescale 1ns/1ps
module pbus_cycle_seq_bench;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int TIM_W  = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              cfg_enable = 1'b1;
    logic [1:0]        cfg_mult = 2'd1;
    logic              cfg_wait_en = 1'b0;
    logic [TIM_W-1:0]  tim_setup = '0, tim_rd_strobe = '0, tim_wr_strobe = '0;
    logic [TIM_W-1:0]  tim_rd_hold = '0, tim_wr_hold = '0, tim_pause = '0;
    logic              bus_ce_n, bus_oe_n, bus_we_n, bus_dout_en;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_dout;
    logic [DATA_W-1:0] bus_din = '0;
    logic              bus_ready = 1'b1;
    logic              rsp_done;
    logic [DATA_W-1:0] rsp_rdata;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 0;
    logic [DATA_W-1:0] last_rd = '0;

    always #2.5 clk = ~clk;

    pbus_cycle_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIM_W(TIM_W)) u_pbus_cycle_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_enable(cfg_enable), .cfg_mult(cfg_mult), .cfg_wait_en(cfg_wait_en),
        .tim_setup(tim_setup), .tim_rd_strobe(tim_rd_strobe), .tim_wr_strobe(tim_wr_strobe),
        .tim_rd_hold(tim_rd_hold), .tim_wr_hold(tim_wr_hold), .tim_pause(tim_pause),
        .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
        .bus_din(bus_din), .bus_ready(bus_ready),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
    );

    function automatic int mult_of(input logic [1:0] code);
        case (code)
            2'd0: return 4;
            2'd1: return 1;
            2'd2: return 2;
            default: return 8;
        endcase
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // One access; w_rdy > 0 raises ready after that many strobe cycles.
    task automatic access(input bit wr, input logic [1:0] mc, input int su, input int st,
                          input int ho, input int pa, input bit wen, input int w_rdy,
                          input bit rdy_low_all);
        int m = mult_of(mc);
        int cs = 0, cst = 0, ch = 0, cp = 0, ndone = 0, guard = 0;
        bit seen = 0, addr_ok = 1, dout_ok = 1, line_ok = 1, done_pos_ok = 1, rd_ok = 1;
        bit done_loop = 0;
        int exp_st;
        logic [ADDR_W-1:0] a   = ADDR_W'($urandom);
        logic [DATA_W-1:0] wd  = DATA_W'($urandom);
        logic [DATA_W-1:0] pat = DATA_W'($urandom);
        logic [DATA_W-1:0] exp_rd;

        if (w_rdy > 0 || rdy_low_all) begin
            bus_ready = 1'b0;
            repeat (3) @(negedge clk);
        end
        cfg_mult = mc; cfg_wait_en = wen; cfg_enable = 1'b1;
        tim_setup = TIM_W'(su);
        tim_rd_strobe = TIM_W'(st); tim_wr_strobe = TIM_W'(st);
        tim_rd_hold = TIM_W'(ho);   tim_wr_hold = TIM_W'(ho);
        tim_pause = TIM_W'(pa);
        req_write = wr; req_addr = a; req_wdata = wd; bus_din = pat;
        check(req_ready == 1'b1, "R12", "ready before access", req_ready, 1);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;

        while (!done_loop) begin
            if (req_ready) begin
                done_loop = 1;
            end else begin
                if (!bus_ce_n) begin
                    if (bus_addr != a) addr_ok = 0;
                    if (wr && (!bus_dout_en || bus_dout != wd)) dout_ok = 0;
                    if (!wr && bus_dout_en) dout_ok = 0;
                    if (!bus_oe_n || !bus_we_n) begin
                        cst++; seen = 1;
                        if (wr ? (bus_we_n || !bus_oe_n) : (bus_oe_n || !bus_we_n)) line_ok = 0;
                    end else if (!seen) cs++;
                    else ch++;
                end else begin
                    cp++;
                    if (!bus_oe_n || !bus_we_n || !seen) line_ok = 0;
                end
                if (rsp_done) begin
                    ndone++;
                    if (!(bus_ce_n && cp == 1)) done_pos_ok = 0;
                    exp_rd = wr ? last_rd : (pat ^ DATA_W'(cst));
                    if (rsp_rdata != exp_rd) rd_ok = 0;
                end
                // stimulus for the next edge
                if (seen && ch == 0 && cp == 0) begin
                    if (!wr) bus_din = pat ^ DATA_W'(cst);
                    if (w_rdy > 0 && cst == w_rdy) bus_ready = 1'b1;
                    if (cst == 1) begin
                        cfg_mult = ~mc; cfg_wait_en = ~wen;
                        tim_setup = TIM_W'($urandom); tim_rd_strobe = TIM_W'($urandom);
                        tim_wr_strobe = TIM_W'($urandom); tim_rd_hold = TIM_W'($urandom);
                        tim_wr_hold = TIM_W'($urandom); tim_pause = TIM_W'($urandom);
                        req_valid = 1'b1; req_addr = ~a; req_write = ~wr;
                    end
                end else if (seen) begin
                    req_valid = 1'b0;
                    bus_din = ~pat;
                end
                guard++;
                if (guard > 5000) done_loop = 1;
                else @(negedge clk);
            end
        end

        exp_st = (st + 1) * m;
        if (wen && w_rdy > 0) exp_st = imax(exp_st, w_rdy + 2);
        check(cs == su * m, "R2/R3", $sformatf("setup clocks mult=%0d", m), cs, su * m);
        check(cst == exp_st, (wen && w_rdy > 0) ? "R7" : (rdy_low_all ? "R8" : "R2/R4"),
              $sformatf("strobe clocks mult=%0d", m), cst, exp_st);
        check(ch == (ho + 1) * m, "R5", $sformatf("hold clocks mult=%0d", m), ch, (ho + 1) * m);
        check(cp == (pa + 1) * m, "R6", $sformatf("pause clocks mult=%0d", m), cp, (pa + 1) * m);
        check(line_ok, "R4", "strobe line selection", line_ok, 1);
        check(addr_ok, "R13", "address held during access", addr_ok, 1);
        check(dout_ok, "R14", "write data drive", dout_ok, 1);
        check(ndone == 1 && done_pos_ok, "R10", "done pulse count/position", ndone, 1);
        exp_rd = wr ? last_rd : (pat ^ DATA_W'(cst));
        check(rd_ok && rsp_rdata == exp_rd, "R9", "read data", rsp_rdata, exp_rd);
        last_rd = exp_rd;
        bus_ready = 1'b1;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(bus_ce_n == 1'b1, "R12", "no restart from request while busy", bus_ce_n, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not finish actual=0 expected=1");
            finish_run();
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5eed_0042);
        repeat (4) @(negedge clk);
        check(bus_ce_n && bus_oe_n && bus_we_n, "R1", "strobes idle in reset",
              {bus_ce_n, bus_oe_n, bus_we_n}, 7);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(bus_ce_n && bus_oe_n && bus_we_n, "R1", "strobes idle after reset",
              {bus_ce_n, bus_oe_n, bus_we_n}, 7);
        check(!bus_dout_en && !rsp_done, "R1", "no drive or done", {bus_dout_en, rsp_done}, 0);
        check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);

        // R2: each multiplier code, read and write, with and without setup
        for (int c = 0; c < 4; c++) begin
            access(1'b0, 2'(c), 2, 3, 1, 2, 1'b0, 0, 1'b0);
            access(1'b1, 2'(c), 0, 1, 0, 0, 1'b0, 0, 1'b0);
        end
        // R3: zero setup with minimum fields
        access(1'b0, 2'd1, 0, 0, 0, 0, 1'b0, 0, 1'b0);
        // R7: wait mode, ready released late and early
        access(1'b0, 2'd1, 1, 1, 1, 1, 1'b1, 17, 1'b0);
        access(1'b1, 2'd2, 0, 0, 0, 0, 1'b1, 9, 1'b0);
        access(1'b0, 2'd3, 1, 4, 0, 0, 1'b1, 3, 1'b0);
        // R8: ready held low but wait mode off
        access(1'b0, 2'd0, 1, 2, 1, 1, 1'b0, 0, 1'b1);

        // R11: disabled region ignores requests
        begin
            bit quiet = 1;
            cfg_enable = 1'b0; req_valid = 1'b1; req_addr = 16'h1234;
            repeat (8) begin
                @(negedge clk);
                if (!bus_ce_n || rsp_done) quiet = 0;
            end
            req_valid = 1'b0; cfg_enable = 1'b1;
            @(negedge clk);
            check(quiet && bus_ce_n, "R11", "no activity while disabled", quiet, 1);
            check(rsp_rdata == last_rd, "R11", "read data untouched", rsp_rdata, last_rd);
        end

        // Constrained random accesses
        for (int i = 0; i < 40; i++) begin
            bit wen = 1'($urandom);
            access(1'($urandom), 2'($urandom), int'($urandom_range(0, 5)),
                   int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
                   int'($urandom_range(0, 3)), wen,
                   wen ? int'($urandom_range(1, 20)) : 0, 1'b0);
        end

        finish_run();
    end

endmodule